// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block gathers single-cycle event and error pulses from the command and data paths of an SD host controller. It latches them into a status register that software clears by writing ones. Two independent enable registers shape the behaviour. The status-enable register decides which events are allowed to latch. The signal-enable register decides which latched bits raise the single interrupt line.

A summary error flag at bit 15 is not stored. It is computed from the error half-word at bits 16 to 31. The card-interrupt bit is a live level and is not a latched pulse. A write-only force register lets software inject error events, which pass through the same status-enable gating as real events.

Software reaches all registers through one small register port. The port has a write strobe, a two-bit word address, write data and combinational read data. The word addresses are: 0 status, 1 status enable, 2 signal enable, 3 force.

Top module: `sdis_top`

## Requirements
- R1: After reset, status, status enable and signal enable all read 0, the force address reads 0, and `irq_o` is 0.
- R2: A pulse on a latching event input sets its status bit one clock later when the matching status-enable bit is 1. The latching bits are 0 command done, 1 data done, 3 DMA, 4 write ready, 5 read ready, 6 card insert, 16 command timeout, 17 command CRC, 18 command end bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end bit, 24 auto-command error and 25 ADMA error.
- R3: A pulse whose status-enable bit is 0 leaves its status bit unchanged.
- R4: Writing status (address 0) clears every latching bit written as 1 and leaves bits written as 0 unchanged.
- R5: When an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R6: Status bit 15 reads 1 exactly when any of bits 16 to 31 is 1, and writing to bit 15 has no effect.
- R7: Status bit 8 reads the level of `card_lvl_i` while status-enable bit 8 is 1, and reads 0 otherwise. A write-one-to-clear does not change it, and `evt_i[8]` has no effect.
- R8: Writing the force register (address 3) sets the error bits 16 to 25 that are written as 1, subject to status enable, in the same way as events. Force bits below 16 have no effect, and the force address reads 0.
- R9: `irq_o` is 1 exactly when some bit of the status read value AND signal enable is 1.
- R10: Status bits 2, 7, 9 to 14, 23 and 26 to 31 always read 0.
- R11: The status-enable and signal-enable registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 status enable, 2 signal enable, 3 force |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_i | input | 32 | Event pulses, one per status bit position |
| card_lvl_i | input | 1 | Card interrupt level |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default 32-bit register width and fixed bit map. With these defaults, every latching, reserved and computed bit position is reachable from random event vectors and random register writes. Directed cases target the collision of a pulse with a clear, masked pulses, force writes that mix low and high bits, and the card level changing while it is masked. A long random run then compares every register and the interrupt line against a bench model.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int ERR_LO     = 16;
    localparam int SUM_BIT    = 15;
    localparam int CARD_BIT   = 8;
    localparam logic [REG_W-1:0] LATCH_MASK = 32'h037F_007B;
    localparam logic [REG_W-1:0] ERR_LATCH  = LATCH_MASK & ~((32'h1 << ERR_LO) - 32'h1);

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 2'd0,
        ADR_STAT_EN = 2'd1,
        ADR_SIG_EN = 2'd2,
        ADR_FORCE = 2'd3
    } sdis_addr_e;
endpackage

// File: rtl/sdis_status.sv
module sdis_status
    import sdis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] stored_o
);
    for (genvar k = 0; k < REG_W; k++) begin : g_bit
        if (LATCH_MASK[k]) begin : g_ff
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         bit_q <= 1'b0;
                else if (set_i[k])  bit_q <= 1'b1;
                else if (clr_i[k])  bit_q <= 1'b0;
            end
            assign stored_o[k] = bit_q;
        end else begin : g_zero
            assign stored_o[k] = 1'b0;
        end
    end

    // R5: a bit set in one cycle is still set in the next
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stored_o & $past(set_i)) == $past(set_i)));
    // R4: a cleared bit without a set is low afterwards
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stored_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/sdis_irq.sv
module sdis_irq
    import sdis_pkg::*;
(
    input  logic [REG_W-1:0] view_i,
    input  logic [REG_W-1:0] sig_en_i,
    output logic             irq_o
);
    always_comb irq_o = |(view_i & sig_en_i);
endmodule

// File: rtl/sdis_top.sv
module sdis_top
    import sdis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              card_lvl_i,
    output logic              irq_o
);
    logic [REG_W-1:0] stat_en_q, sig_en_q;
    logic [REG_W-1:0] clr_vec, frc_vec, set_vec, stored, view;
    sdis_addr_e       addr;

    assign addr = sdis_addr_e'(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_en_q <= '0;
            sig_en_q  <= '0;
        end else if (reg_wr) begin
            if (addr == ADR_STAT_EN) stat_en_q <= reg_wdata;
            if (addr == ADR_SIG_EN)  sig_en_q  <= reg_wdata;
        end
    end

    always_comb begin
        clr_vec = (reg_wr && addr == ADR_STATUS) ? reg_wdata : '0;
        frc_vec = (reg_wr && addr == ADR_FORCE) ? (reg_wdata & ERR_LATCH) : '0;
        set_vec = (evt_i | frc_vec) & stat_en_q & LATCH_MASK;
    end

    sdis_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .stored_o (stored)
    );

    always_comb begin
        view           = stored;
        view[CARD_BIT] = card_lvl_i & stat_en_q[CARD_BIT];
        view[SUM_BIT]  = |stored[REG_W-1:ERR_LO];
    end

    sdis_irq u_irq (
        .view_i   (view),
        .sig_en_i (sig_en_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        unique case (addr)
            ADR_STATUS:  reg_rdata = view;
            ADR_STAT_EN: reg_rdata = stat_en_q;
            ADR_SIG_EN:  reg_rdata = sig_en_q;
            default:     reg_rdata = '0;
        endcase
    end

    // R6: summary bit follows the error half-word on the read port
    a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[SUM_BIT] == |reg_rdata[REG_W-1:ERR_LO]));
    // R10: reserved status positions stay low
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> ((reg_rdata & ~(LATCH_MASK | (32'h1 << SUM_BIT) | (32'h1 << CARD_BIT))) == '0));
    // R3: no bit rises whose status enable was low
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stored & ~$past(stored) & ~$past(stat_en_q)) == '0));
    // R9: interrupt line matches enabled status
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(view & sig_en_q));
endmodule

// File: tb/tb_sdis_top.sv
`timescale 1ns/100ps
module tb_sdis_top;
    localparam logic [31:0] LMASK = 32'h037F_007B;
    localparam logic [31:0] EMASK = 32'h037F_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_i = '0;
    logic        card_lvl_i = 1'b0;
    logic        irq_o;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] m_st = '0, m_en = '0, m_sig = '0;

    sdis_top dut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] view_f(logic [31:0] st, logic [31:0] en, logic card);
        logic [31:0] v = st;
        v[8]  = card & en[8];
        v[15] = |st[31:16];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic wr, logic [1:0] a, logic [31:0] d, logic [31:0] e);
        logic [31:0] clr, frc, set;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = e;
        @(posedge clk);
        clr = (wr && a == 2'd0) ? d : '0;
        frc = (wr && a == 2'd3) ? (d & EMASK) : '0;
        set = (e | frc) & m_en & LMASK;
        m_st = (m_st & ~clr) | set;
        if (wr && a == 2'd1) m_en = d;
        if (wr && a == 2'd2) m_sig = d;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = '0;
        v = view_f(m_st, m_en, card_lvl_i);
        reg_addr = 2'd0; #1 chk(req, reg_rdata, v);
        reg_addr = 2'd1; #1 chk(req, reg_rdata, m_en);
        reg_addr = 2'd2; #1 chk(req, reg_rdata, m_sig);
        reg_addr = 2'd3; #1 chk(req, reg_rdata, 32'h0);
        chk({req, " irq"}, {31'h0, irq_o}, {31'h0, |(v & m_sig)});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        check_all("R1 after release");
        // R11 readback
        step(1, 2'd1, 32'hFFFF_FFFF, '0);
        step(1, 2'd2, 32'hA5A5_5A5A, '0);
        check_all("R11 readback");
        step(1, 2'd2, 32'h0, '0);
        // R2 latch
        step(0, 2'd0, 0, 32'h0000_0003);
        check_all("R2 latch");
        // R4 clear one of two
        step(1, 2'd0, 32'h0000_0001, '0);
        check_all("R4 clear");
        // R5 collision
        step(1, 2'd0, 32'h0000_0010, 32'h0000_0010);
        check_all("R5 collision");
        // R3 masked event
        step(1, 2'd1, 32'hFFFF_FFDF, '0);
        step(0, 2'd0, 0, 32'h0000_0020);
        check_all("R3 masked");
        // R6 summary
        step(1, 2'd1, 32'hFFFF_FFFF, '0);
        step(0, 2'd0, 0, 32'h0001_0000);
        check_all("R6 summary set");
        step(1, 2'd0, 32'h0000_8000, '0);
        check_all("R6 write bit15 ignored");
        step(1, 2'd0, 32'h0001_0000, '0);
        check_all("R6 summary clear");
        // R7 card level
        card_lvl_i = 1'b1;
        check_all("R7 card level");
        step(1, 2'd0, 32'h0000_0100, 32'h0000_0100);
        check_all("R7 clear ignored");
        step(1, 2'd1, 32'hFFFF_FEFF, '0);
        check_all("R7 masked");
        card_lvl_i = 1'b0;
        step(1, 2'd1, 32'hFFFF_FFFF, '0);
        // R8 force
        step(1, 2'd3, 32'h0200_00FF, '0);
        check_all("R8 force");
        step(1, 2'd1, 32'hFFEF_FFFF, '0);
        step(1, 2'd3, 32'h0010_0000, '0);
        check_all("R8 force masked");
        // R9 irq via summary and plain bit
        step(1, 2'd2, 32'h0000_8000, '0);
        check_all("R9 irq summary");
        step(1, 2'd0, 32'hFFFF_FFFF, '0);
        check_all("R9 irq off");
        // R10 reserved events
        step(0, 2'd0, 0, 32'hFC80_7E84);
        check_all("R10 reserved");
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            card_lvl_i = r[31];
            step(r[3:0] < 4'd6, r[5:4], $urandom, $urandom & $urandom);
            if (r[8:6] == 3'd0) check_all("R2 R4 R9 random");
        end
        check_all("R2 R4 R9 random end");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule